// File: doc/BRIEF.md
# Ethernet Transmit Frame Sequencer

This block turns one queued transmit frame into a byte-per-cycle stream on a line-side port. It addresses the frame buffer itself through a byte index and puts each stored byte on the line in order. Before the payload it sends a fixed lead-in of seven 0x55 bytes and one 0xD5 delimiter. After the payload it can add zero fill so the frame reaches the Ethernet minimum length. It can also append a CRC-32 check sequence, or leave the check bytes to software.

Starting a frame depends on an internal enable bit, which the host sets with a one-cycle pulse. The block itself clears that bit on serious faults. In normal operation the block waits for the carrier to go low before it starts; it does no other deferral or backoff. Control inputs select several options: carrier monitoring, which aborts a frame when its own carrier is missing; stop-on-SQE-error; and a forced-collision test mode that starts on a rising carrier edge instead of waiting for silence. A one-cycle done pulse retires each frame that reached the line, and four sticky fault flags report what happened.

Top module: `txFrameSequencer`

## Requirements
- R1: A started frame is sent one byte per cycle. The order is seven bytes of 0x55, then one byte of 0xD5, then payload bytes 0 to frameLen-1 read at rdAddr 0 upward.
- R2: With forceCol low, a frame starts only when txEnable is 1, a frame is queued and carrierSense is low. While carrierSense stays high, nothing is sent.
- R3: With noCrc low, four check bytes follow the payload and any fill. They hold the inverted reflected CRC-32 (polynomial 0x04C11DB7, preset all ones) over payload plus fill, least significant byte first.
- R4: With noCrc high, no check bytes are added, and the last payload byte is the last byte on the line.
- R5: With padEn high, a payload shorter than 60 bytes (or 64 when noCrc is high) gets 0x00 bytes until it reaches that size. With padEn low, or with a payload already at that size or longer, no fill is added.
- R6: With monCarrier high, if carrierSense was never high during the seven lead-in bytes, the line stops after the seventh byte with no delimiter. abortFlag and carrierLostFlag are then set and txEnable clears.
- R7: With monCarrier high, if carrierSense is low in any cycle from the delimiter onward, the byte of that cycle is the last one sent and no check bytes follow. abortFlag and carrierLostFlag are then set and txEnable clears.
- R8: With monCarrier low, carrierSense has no effect once a frame has started, and the whole frame is sent.
- R9: A pulse on sqeError during a frame sets sqeFlag, and the frame still completes. If stopOnSqe is high, txEnable clears at the end of that frame and the next queued frame is held back. If stopOnSqe is low, txEnable stays 1 and the next queued frame follows.
- R10: With forceCol high and no frame queued, a rising edge of carrierSense causes exactly seven 0x55 bytes to be sent, with no delimiter and no done pulse.
- R11: With forceCol high and a frame queued, the frame starts on a rising edge of carrierSense, not while the carrier is low, and sends the full lead-in, the delimiter and the payload.
- R12: A collision input seen at a clock edge while a payload, fill or check byte is on the line makes that byte the last one sent. It sets abortFlag and lateColFlag. txEnable clears only when forceCol is high.
- R13: After reset, lineValid, txEnable, doneStb and all flags are 0. doneStb pulses for one cycle right after the last byte of every frame that got past the lead-in. The flags hold until the next frame starts, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enSet | input | 1 | One-cycle pulse that sets txEnable |
| padEn | input | 1 | Zero-fill short frames |
| noCrc | input | 1 | Do not append check bytes |
| monCarrier | input | 1 | Abort if own carrier is missing |
| stopOnSqe | input | 1 | Clear enable after a frame with an SQE error |
| forceCol | input | 1 | Forced-collision test mode |
| frameReady | input | 1 | A frame is queued in the buffer |
| frameLen | input | LEN_W | Payload byte count of the queued frame (at least 1) |
| rdAddr | output | LEN_W | Payload byte index into the buffer |
| rdData | input | 8 | Buffer byte at rdAddr, same cycle |
| carrierSense | input | 1 | Line carrier indication |
| sqeError | input | 1 | SQE test error pulse |
| collision | input | 1 | Collision indication |
| lineData | output | 8 | Line byte |
| lineValid | output | 1 | lineData carries a byte this cycle |
| txEnable | output | 1 | Transmit enable state |
| doneStb | output | 1 | Frame finished or aborted; buffer drops the frame |
| abortFlag | output | 1 | Last frame was cut short |
| carrierLostFlag | output | 1 | Abort caused by missing carrier |
| sqeFlag | output | 1 | SQE error seen in last frame |
| lateColFlag | output | 1 | Collision after the delimiter |

## Verification
The hardest situations to reach are those where the carrier changes in a fixed cycle relative to the bytes the block is sending. Examples are the carrier dropping on one chosen payload byte, the carrier never appearing during the lead-in, and a collision arriving on a known byte. To reach them, the stimulus derives carrierSense from lineValid as an echo of the block's own output. It cuts that echo, or raises collision or sqeError, when the count of captured line bytes reaches a chosen value. Each abort therefore lands on a byte index the bench knows in advance. Forced-collision starts are reached by holding the carrier low with a frame queued and then raising it.

// File: rtl/txSeqPkg.sv
package txSeqPkg;

  localparam int          FCS_BYTES    = 4;
  localparam logic [7:0]  LEAD_BYTE    = 8'h55;
  localparam logic [7:0]  DELIM_BYTE   = 8'hD5;
  localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_DELIM, ST_DATA, ST_FILL, ST_CHECK, ST_END
  } txState_e;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LEAD, SEL_DELIM, SEL_DATA, SEL_FILL, SEL_CHECK
  } byteSel_e;

  // Strobes from the sequencer control to the datapath
  typedef struct packed {
    logic     cntClr;
    logic     cntInc;
    logic     crcInit;
    logic     crcUpd;
    byteSel_e sel;
  } dpCtrl_t;

  // Reflected CRC-32, one byte, LSB first
  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/txDatapath.sv
module txDatapath
  import txSeqPkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [7:0]       rdData,
  output logic [LEN_W-1:0] cnt,
  output logic [7:0]       lineData,
  output logic             lineValid
);

  logic [LEN_W-1:0] cntQ;
  logic [31:0]      crcQ;
  logic [31:0]      checkWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      crcQ <= '1;
    end else begin
      if (ctl.cntClr)      cntQ <= '0;
      else if (ctl.cntInc) cntQ <= cntQ + 1'b1;

      if (ctl.crcInit)     crcQ <= '1;
      else if (ctl.crcUpd) crcQ <= crcStep(crcQ, lineData);
    end
  end

  assign checkWord = ~crcQ;
  assign cnt       = cntQ;
  assign lineValid = (ctl.sel != SEL_NONE);

  always_comb begin
    case (ctl.sel)
      SEL_LEAD:  lineData = LEAD_BYTE;
      SEL_DELIM: lineData = DELIM_BYTE;
      SEL_DATA:  lineData = rdData;
      SEL_CHECK: lineData = checkWord[{cntQ[1:0], 3'b000} +: 8];
      default:   lineData = 8'h00;
    endcase
  end

  // R3: only four check bytes are ever indexed
  assert_check_index_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == SEL_CHECK) |-> (cntQ < LEN_W'(FCS_BYTES)));

endmodule

// File: rtl/txControl.sv
module txControl
  import txSeqPkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int LEAD_LEN  = 7,
  parameter int MIN_FRAME = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enSet,
  input  logic             padEn,
  input  logic             noCrc,
  input  logic             monCarrier,
  input  logic             stopOnSqe,
  input  logic             forceCol,
  input  logic             frameReady,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             carrierSense,
  input  logic             sqeError,
  input  logic             collision,
  input  logic [LEN_W-1:0] cnt,
  output dpCtrl_t          ctl,
  output logic             txEnable,
  output logic             doneStb,
  output logic             abortFlag,
  output logic             carrierLostFlag,
  output logic             sqeFlag,
  output logic             lateColFlag
);

  localparam logic [LEN_W-1:0] LEAD_LAST  = LEAD_LEN - 1;
  localparam logic [LEN_W-1:0] CHECK_LAST = FCS_BYTES - 1;
  localparam logic [LEN_W-1:0] MIN_NOCRC  = MIN_FRAME;
  localparam logic [LEN_W-1:0] MIN_CRC    = MIN_FRAME - FCS_BYTES;

  txState_e         stateQ, stateD;
  logic             enQ, hasFrameQ, carrierSeenQ, carrierPrevQ;
  logic             abortQ, lostQ, sqeQ, lateQ;
  logic             startNow, lostNow, lateNow;
  logic [LEN_W-1:0] minLen;
  txState_e         tailState;

  assign minLen    = noCrc ? MIN_NOCRC : MIN_CRC;
  assign tailState = noCrc ? ST_END : ST_CHECK;

  always_comb begin
    stateD   = stateQ;
    ctl      = '{cntClr: 1'b0, cntInc: 1'b0, crcInit: 1'b0, crcUpd: 1'b0, sel: SEL_NONE};
    startNow = 1'b0;
    lostNow  = 1'b0;
    lateNow  = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (enQ) begin
          if (forceCol) startNow = carrierSense && !carrierPrevQ;
          else          startNow = frameReady && !carrierSense;
        end
        if (startNow) begin
          stateD      = ST_LEAD;
          ctl.cntClr  = 1'b1;
          ctl.crcInit = 1'b1;
        end
      end
      ST_LEAD: begin
        ctl.sel    = SEL_LEAD;
        ctl.cntInc = 1'b1;
        if (cnt == LEAD_LAST) begin
          ctl.cntClr = 1'b1;
          if (!hasFrameQ) stateD = ST_IDLE;
          else if (monCarrier && !(carrierSeenQ || carrierSense)) begin
            lostNow = 1'b1;
            stateD  = ST_END;
          end else stateD = ST_DELIM;
        end
      end
      ST_DELIM: begin
        ctl.sel = SEL_DELIM;
        if (monCarrier && !carrierSense) begin
          lostNow = 1'b1;
          stateD  = ST_END;
        end else begin
          ctl.cntClr = 1'b1;
          stateD     = ST_DATA;
        end
      end
      ST_DATA, ST_FILL, ST_CHECK: begin
        ctl.sel    = (stateQ == ST_DATA) ? SEL_DATA :
                     (stateQ == ST_FILL) ? SEL_FILL : SEL_CHECK;
        ctl.cntInc = 1'b1;
        ctl.crcUpd = (stateQ != ST_CHECK);
        if (collision) begin
          lateNow = 1'b1;
          stateD  = ST_END;
        end else if (monCarrier && !carrierSense) begin
          lostNow = 1'b1;
          stateD  = ST_END;
        end else if (stateQ == ST_DATA && cnt == frameLen - 1'b1) begin
          if (padEn && frameLen < minLen) stateD = ST_FILL;
          else begin
            stateD     = tailState;
            ctl.cntClr = 1'b1;
          end
        end else if (stateQ == ST_FILL && cnt == minLen - 1'b1) begin
          stateD     = tailState;
          ctl.cntClr = 1'b1;
        end else if (stateQ == ST_CHECK && cnt == CHECK_LAST) begin
          stateD = ST_END;
        end
      end
      ST_END:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ       <= ST_IDLE;
      enQ          <= 1'b0;
      hasFrameQ    <= 1'b0;
      carrierSeenQ <= 1'b0;
      carrierPrevQ <= 1'b0;
      abortQ       <= 1'b0;
      lostQ        <= 1'b0;
      sqeQ         <= 1'b0;
      lateQ        <= 1'b0;
    end else begin
      stateQ       <= stateD;
      carrierPrevQ <= carrierSense;
      if (startNow) begin
        hasFrameQ    <= frameReady;
        carrierSeenQ <= 1'b0;
        abortQ       <= 1'b0;
        lostQ        <= 1'b0;
        sqeQ         <= 1'b0;
        lateQ        <= 1'b0;
      end else begin
        if (stateQ == ST_LEAD && carrierSense) carrierSeenQ <= 1'b1;
        if (stateQ inside {ST_LEAD, ST_DELIM, ST_DATA, ST_FILL, ST_CHECK} && sqeError)
          sqeQ <= 1'b1;
        if (lostNow || lateNow) abortQ <= 1'b1;
        if (lostNow) lostQ <= 1'b1;
        if (lateNow) lateQ <= 1'b1;
      end
      if (lostNow || (lateNow && forceCol) || (stateQ == ST_END && stopOnSqe && sqeQ))
        enQ <= 1'b0;
      else if (enSet)
        enQ <= 1'b1;
    end
  end

  assign txEnable        = enQ;
  assign doneStb         = (stateQ == ST_END);
  assign abortFlag       = abortQ;
  assign carrierLostFlag = lostQ;
  assign sqeFlag         = sqeQ;
  assign lateColFlag     = lateQ;

  assert_delim_after_lead_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DELIM) |-> ($past(stateQ) == ST_LEAD));

  assert_defer_on_carrier_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !forceCol && carrierSense) |=> (stateQ != ST_LEAD));

  assert_idle_when_disabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !txEnable) |=> (stateQ == ST_IDLE));

  assert_no_check_bytes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (noCrc && stateQ != ST_CHECK) |=> (stateQ != ST_CHECK));

  assert_carrier_abort_R7: assert property (@(posedge clk) disable iff (!rstN)
    (monCarrier && !carrierSense && !collision &&
     stateQ inside {ST_DELIM, ST_DATA, ST_FILL, ST_CHECK})
    |=> (stateQ == ST_END && carrierLostFlag && !txEnable));

  assert_sqe_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_END && stopOnSqe && sqeFlag) |=> !txEnable);

  assert_forced_late_col_R12: assert property (@(posedge clk) disable iff (!rstN)
    (forceCol && collision && stateQ inside {ST_DATA, ST_FILL, ST_CHECK})
    |=> (lateColFlag && abortFlag && !txEnable));

endmodule

// File: rtl/txFrameSequencer.sv
module txFrameSequencer
  import txSeqPkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int LEAD_LEN  = 7,
  parameter int MIN_FRAME = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enSet,
  input  logic             padEn,
  input  logic             noCrc,
  input  logic             monCarrier,
  input  logic             stopOnSqe,
  input  logic             forceCol,
  input  logic             frameReady,
  input  logic [LEN_W-1:0] frameLen,
  output logic [LEN_W-1:0] rdAddr,
  input  logic [7:0]       rdData,
  input  logic             carrierSense,
  input  logic             sqeError,
  input  logic             collision,
  output logic [7:0]       lineData,
  output logic             lineValid,
  output logic             txEnable,
  output logic             doneStb,
  output logic             abortFlag,
  output logic             carrierLostFlag,
  output logic             sqeFlag,
  output logic             lateColFlag
);

  dpCtrl_t          ctl;
  logic [LEN_W-1:0] cnt;

  txControl #(.LEN_W(LEN_W), .LEAD_LEN(LEAD_LEN), .MIN_FRAME(MIN_FRAME)) u_ctrl (
    .clk(clk), .rstN(rstN), .enSet(enSet), .padEn(padEn), .noCrc(noCrc),
    .monCarrier(monCarrier), .stopOnSqe(stopOnSqe), .forceCol(forceCol),
    .frameReady(frameReady), .frameLen(frameLen), .carrierSense(carrierSense),
    .sqeError(sqeError), .collision(collision), .cnt(cnt), .ctl(ctl),
    .txEnable(txEnable), .doneStb(doneStb), .abortFlag(abortFlag),
    .carrierLostFlag(carrierLostFlag), .sqeFlag(sqeFlag), .lateColFlag(lateColFlag)
  );

  txDatapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdData(rdData), .cnt(cnt),
    .lineData(lineData), .lineValid(lineValid)
  );

  assign rdAddr = cnt;

endmodule

// File: tb/tb_txFrameSequencer.sv
`timescale 1ns/1ps
module tb_txFrameSequencer;

  localparam int LEN_W = 11;

  typedef struct packed {
    logic [10:0] len;
    logic        pad;
    logic        nocrc;
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{11'd20, 1'b1, 1'b0, 8'h10},   // short, filled to 60, CRC
    '{11'd20, 1'b0, 1'b0, 8'h21},   // short, no fill, CRC
    '{11'd60, 1'b1, 1'b0, 8'h32},   // exactly at threshold
    '{11'd59, 1'b1, 1'b0, 8'h43},   // one fill byte
    '{11'd20, 1'b1, 1'b1, 8'h54},   // filled to 64, no CRC
    '{11'd64, 1'b1, 1'b1, 8'h65},   // at no-CRC threshold
    '{11'd1,  1'b1, 1'b0, 8'h76}    // single byte payload
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, enSet, padEn, noCrc, monCarrier, stopOnSqe, forceCol;
  logic [LEN_W-1:0] frameLen, rdAddr;
  logic [7:0] rdData, lineData;
  logic carrierSense = 1'b0, sqeError = 1'b0, collision = 1'b0;
  logic frameReady, lineValid, txEnable, doneStb;
  logic abortFlag, carrierLostFlag, sqeFlag, lateColFlag;

  logic [7:0] mem [0:255];
  logic [7:0] cap [0:4095];
  logic [7:0] expArr [0:255];
  logic [3:0] flagsAt [0:63];
  int expN;
  int capN = 0, doneCnt = 0, queued = 0, base = 0;
  int dropAt = -1, colAt = -1, sqeAt = -1;
  logic echo = 1'b0, carrierLevel = 1'b0;
  int checks = 0, fails = 0;

  assign rdData     = mem[rdAddr[7:0]];
  assign frameReady = (queued > doneCnt);

  txFrameSequencer #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .enSet(enSet), .padEn(padEn), .noCrc(noCrc),
    .monCarrier(monCarrier), .stopOnSqe(stopOnSqe), .forceCol(forceCol),
    .frameReady(frameReady), .frameLen(frameLen), .rdAddr(rdAddr), .rdData(rdData),
    .carrierSense(carrierSense), .sqeError(sqeError), .collision(collision),
    .lineData(lineData), .lineValid(lineValid), .txEnable(txEnable), .doneStb(doneStb),
    .abortFlag(abortFlag), .carrierLostFlag(carrierLostFlag), .sqeFlag(sqeFlag),
    .lateColFlag(lateColFlag)
  );

  // Line capture and line-side stimulus, away from the active edge
  always @(negedge clk) begin
    if (lineValid) begin
      cap[capN % 4096] = lineData;
      capN = capN + 1;
    end
    if (doneStb) begin
      flagsAt[doneCnt % 64] = {abortFlag, carrierLostFlag, sqeFlag, lateColFlag};
      doneCnt = doneCnt + 1;
    end
    carrierSense <= echo ? (lineValid && (dropAt < 0 || (capN - base) < dropAt)) : carrierLevel;
    collision    <= (colAt >= 0) && ((capN - base) == colAt);
    sqeError     <= (sqeAt >= 0) && ((capN - base) == sqeAt);
  end

  function automatic logic [31:0] refCrc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic buildExp(input int len, input bit pad, input bit nocrc, input logic [7:0] seed);
    int target;
    logic [31:0] c;
    for (int i = 0; i < len; i++) mem[i] = seed + 8'(i * 7);
    frameLen = LEN_W'(len);
    padEn = pad;
    noCrc = nocrc;
    expN = 0;
    for (int i = 0; i < 7; i++) begin expArr[expN] = 8'h55; expN++; end
    expArr[expN] = 8'hD5; expN++;
    target = (pad && len < (nocrc ? 64 : 60)) ? (nocrc ? 64 : 60) : len;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < target; i++) begin
      expArr[expN] = (i < len) ? mem[i] : 8'h00;
      c = refCrc(c, expArr[expN]);
      expN++;
    end
    if (!nocrc) for (int i = 0; i < 4; i++) begin expArr[expN] = ~c[8*i +: 8]; expN++; end
  endtask

  task automatic cmpStream(input string req, input int n);
    int bad;
    bad = -1;
    for (int i = 0; i < n; i++)
      if (bad < 0 && cap[(base + i) % 4096] != expArr[i]) bad = i;
    if (bad < 0) checkEq(req, "line bytes", 0, 0);
    else checkEq(req, $sformatf("line byte %0d", bad), int'(cap[(base + bad) % 4096]), int'(expArr[bad]));
  endtask

  task automatic waitDone(input int target);
    int t;
    t = 0;
    while (doneCnt < target && t < 3000) begin tick(1); t++; end
    tick(2);
  endtask

  task automatic pulseEn();
    enSet = 1'b1; tick(1); enSet = 1'b0;
  endtask

  initial begin
    int d0;
    rstN = 1'b0; enSet = 1'b0; padEn = 1'b0; noCrc = 1'b0; monCarrier = 1'b0;
    stopOnSqe = 1'b0; forceCol = 1'b0; frameLen = '0;
    tick(3);
    // R13: reset state
    checkEq("R13", "reset lineValid", int'(lineValid), 0);
    checkEq("R13", "reset txEnable", int'(txEnable), 0);
    checkEq("R13", "reset flags", int'({doneStb, abortFlag, carrierLostFlag, sqeFlag, lateColFlag}), 0);
    rstN = 1'b1;
    tick(2);

    // Vector table: R1 R3 R4 R5 with echoed carrier under monitoring
    monCarrier = 1'b1; echo = 1'b1;
    pulseEn();
    foreach (VECS[v]) begin
      buildExp(int'(VECS[v].len), VECS[v].pad, VECS[v].nocrc, VECS[v].seed);
      base = capN; d0 = doneCnt; queued++;
      waitDone(d0 + 1);
      checkEq("R5", $sformatf("vec %0d byte count", v), capN - base, expN);
      cmpStream(VECS[v].nocrc ? "R4" : "R3", expN);
      checkEq("R1", $sformatf("vec %0d clean status", v), int'(flagsAt[d0 % 64]), 0);
    end

    // R2 deferral, then R8 carrier ignored with monitoring off
    monCarrier = 1'b0; echo = 1'b0; carrierLevel = 1'b1;
    buildExp(30, 1'b0, 1'b0, 8'h88);
    base = capN; d0 = doneCnt; queued++;
    tick(30);
    checkEq("R2", "bytes while carrier high", capN - base, 0);
    carrierLevel = 1'b0;
    waitDone(d0 + 1);
    checkEq("R8", "full frame, carrier low", capN - base, expN);
    cmpStream("R8", expN);
    checkEq("R8", "no abort", int'(abortFlag), 0);

    // R6: carrier never seen during lead-in
    monCarrier = 1'b1;
    buildExp(30, 1'b0, 1'b0, 8'h99);
    base = capN; d0 = doneCnt; queued++;
    waitDone(d0 + 1);
    checkEq("R6", "bytes sent", capN - base, 7);
    cmpStream("R6", 7);
    checkEq("R6", "abort+lost flags", int'({abortFlag, carrierLostFlag}), 3);
    checkEq("R6", "enable cleared", int'(txEnable), 0);
    tick(5);
    checkEq("R13", "flags held after frame", int'(carrierLostFlag), 1);

    // R7: carrier drops after 20 bytes
    echo = 1'b1; dropAt = 20;
    pulseEn();
    buildExp(40, 1'b0, 1'b0, 8'hA1);
    base = capN; d0 = doneCnt; queued++;
    waitDone(d0 + 1);
    checkEq("R7", "bytes sent", capN - base, 20);
    cmpStream("R7", 20);
    checkEq("R7", "lost flag at done", int'(flagsAt[d0 % 64]), 4'b1100);
    checkEq("R7", "enable cleared", int'(txEnable), 0);
    dropAt = -1;

    // R13: flags cleared by next start
    pulseEn();
    buildExp(30, 1'b0, 1'b0, 8'hB2);
    base = capN; d0 = doneCnt; queued++;
    waitDone(d0 + 1);
    checkEq("R13", "flags cleared on new frame", int'(flagsAt[d0 % 64]), 0);
    checkEq("R13", "one done pulse", doneCnt - d0, 1);

    // R9 with stop: second frame held back
    stopOnSqe = 1'b1; sqeAt = 20;
    buildExp(30, 1'b0, 1'b0, 8'hC3);
    base = capN; d0 = doneCnt; queued += 2;
    waitDone(d0 + 1);
    tick(20);
    checkEq("R9", "stop: bytes sent", capN - base, expN);
    checkEq("R9", "stop: sqe flag at done", int'(flagsAt[d0 % 64]), 4'b0010);
    checkEq("R9", "stop: enable cleared", int'(txEnable), 0);
    checkEq("R9", "stop: second frame held", doneCnt - d0, 1);
    queued = doneCnt;

    // R9 without stop: both frames sent
    stopOnSqe = 1'b0;
    pulseEn();
    base = capN; d0 = doneCnt; queued += 2;
    waitDone(d0 + 2);
    checkEq("R9", "no stop: bytes sent", capN - base, 2 * expN);
    checkEq("R9", "no stop: sqe flag first", int'(flagsAt[d0 % 64]), 4'b0010);
    checkEq("R9", "no stop: enable kept", int'(txEnable), 1);
    sqeAt = -1;

    // R12 late collision without forced mode
    colAt = 12;
    buildExp(30, 1'b0, 1'b0, 8'hD4);
    base = capN; d0 = doneCnt; queued++;
    waitDone(d0 + 1);
    checkEq("R12", "bytes sent", capN - base, 12);
    checkEq("R12", "abort+late flags", int'({abortFlag, lateColFlag}), 3);
    checkEq("R12", "enable kept", int'(txEnable), 1);
    colAt = -1;

    // R10 forced mode, empty queue
    forceCol = 1'b1; monCarrier = 1'b0; echo = 1'b0; carrierLevel = 1'b0;
    tick(5);
    base = capN; d0 = doneCnt;
    carrierLevel = 1'b1;
    tick(30);
    checkEq("R10", "lead-in only", capN - base, 7);
    cmpStream("R10", 7);
    checkEq("R10", "no done pulse", doneCnt - d0, 0);

    // R11 forced mode with frame, R12 forced late collision
    carrierLevel = 1'b0;
    tick(3);
    buildExp(30, 1'b0, 1'b0, 8'hE5);
    base = capN; d0 = doneCnt; queued++;
    tick(10);
    checkEq("R11", "no start without carrier rise", capN - base, 0);
    colAt = 15;
    carrierLevel = 1'b1;
    waitDone(d0 + 1);
    checkEq("R11", "bytes before collision", capN - base, 15);
    cmpStream("R11", 15);
    checkEq("R12", "forced late col flags", int'(flagsAt[d0 % 64]), 4'b1001);
    checkEq("R12", "forced: enable cleared", int'(txEnable), 0);
    colAt = -1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule